// File: doc/BRIEF.md
# Coalescing Register-Write Command Packer

This block turns a stream of register-write requests into command words in a 2048-dword command memory, which a separate executor later reads. Each request is either a plain write or an indexed write. It carries a 20-bit register offset and a 32-bit value. The block drives the memory's write port with one dword per cycle. It keeps a tail pointer, which is the next free dword, and it remembers where the most recent instruction began.

Every instruction starts on an even dword. A plain write becomes a value dword followed by a header dword. An indexed write opens a burst instruction: a count dword, a header dword, then the value. When further indexed writes target the same register as the burst that is still open, their values are appended to that burst and its count dword is rewritten with the new total. If a request leaves the tail on an odd dword, a zero is written at the tail so the instruction ends padded. A request that cannot fit in full is dropped and sets a sticky overflow flag. A clear input empties the buffer bookkeeping.

Top module: `regwr_packer`

## Requirements
- R1: An accepted plain write that fits places its value at the even position P, and at P+1 a header with 0x01 in bits 31:24, 0xF in bits 23:20 and the offset in bits 19:0. The tail becomes P+2.
- R2: An accepted indexed write that does not merge opens a burst at the even position P. It writes 1 at P, a header at P+1 with 0x09 in bits 31:24, zero in bits 23:20 and the offset in bits 19:0, and the value at P+2. The tail becomes P+3.
- R3: An indexed write whose offset equals that of the open burst, arriving when the previous non-dropped request was indexed, writes its value at the tail. It then rewrites the burst's first dword with the incremented count, and the tail grows by one.
- R4: Whenever the tail is odd after an accepted request, a zero dword is written at the tail, and the tail stays where it is.
- R5: A plain write closes the open burst. An indexed write after it opens a new burst even when its offset matches the old one.
- R6: A new plain write or a new burst first rounds an odd tail up to the next even position. A plain write therefore always leaves an even tail.
- R7: A request is dropped when a plain write cannot fit both dwords, when a new burst cannot fit three dwords, or when a merge finds the tail at 2048. A dropped request writes nothing and leaves the tail unchanged. It sets the overflow flag, which stays set until clear.
- R8: A one-cycle clear sets the tail to 0, clears overflow and closes any open burst.
- R9: Emission starts in the cycle after a request is accepted and writes one dword per cycle. The ready output stays low for exactly as many cycles as dwords are written, and a dropped request keeps ready high.
- R10: After reset the tail is 0, overflow is low, ready is high and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Empties the buffer bookkeeping; ready is low while it is high |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can take a request this cycle |
| req_indexed | input | 1 | 1 = indexed (burst-capable) write, 0 = plain write |
| req_offset | input | 20 | Target register offset |
| req_value | input | 32 | Value to write |
| mem_we | output | 1 | Command memory write strobe |
| mem_addr | output | 11 | Command memory dword address |
| mem_wdata | output | 32 | Command memory write data |
| tail | output | 12 | Next free dword position (0 to 2048) |
| overflow | output | 1 | Sticky flag: a request was dropped for lack of room |

## Verification
The assertions assume that a request is taken only in a cycle where both valid and ready are high, and that clear is never asserted while a merge or a drop is being judged in the same cycle. The design enforces the second point by pulling ready low during clear. The stimulus offers each request for a single cycle and only once ready has returned, and it pulses clear only between requests. As a result, every change of the tail, every write burst and every overflow edge can be traced to exactly one request. The random phase draws offsets from a small set, so merges, closed bursts and re-openings occur often. The directed phases fill the buffer to its last dwords to exercise each drop condition.

// File: rtl/regwr_pack_pkg.sv
`timescale 1ns/1ps
package regwr_pack_pkg;
  // Number of dword slots a single request can produce at most.
  localparam int unsigned SLOTS = 4;

  localparam logic [7:0] OP_PLAIN = 8'h01;
  localparam logic [7:0] OP_BURST = 8'h09;
  localparam logic [3:0] BE_ALL   = 4'hF;
  localparam logic [3:0] BE_NONE  = 4'h0;

  typedef enum logic [1:0] {
    ACT_DROP  = 2'd0,
    ACT_PLAIN = 2'd1,
    ACT_OPEN  = 2'd2,
    ACT_MERGE = 2'd3
  } act_e;
endpackage

// File: rtl/regwr_plan.sv
`timescale 1ns/1ps
// Combinational planner: decides what an incoming request turns into and
// which dwords go where, plus the bookkeeping after it.
module regwr_plan
  import regwr_pack_pkg::*;
#(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned OFF_W  = 20,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = $clog2(DEPTH),
  parameter int unsigned PW     = AW + 1,
  parameter int unsigned NW     = $clog2(SLOTS + 1)
) (
  input  logic              req_indexed,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_value,
  input  logic [PW-1:0]     free_q,
  input  logic [AW-1:0]     start_q,
  input  logic              open_q,
  input  logic [OFF_W-1:0]  off_q,
  input  logic [PW-1:0]     cnt_q,
  output act_e              act,
  output logic [AW-1:0]     slot_addr [SLOTS],
  output logic [DATA_W-1:0] slot_data [SLOTS],
  output logic [NW-1:0]     slot_n,
  output logic [PW-1:0]     free_d,
  output logic [AW-1:0]     start_d,
  output logic              open_d,
  output logic [OFF_W-1:0]  off_d,
  output logic [PW-1:0]     cnt_d
);

  localparam logic [PW:0] LIMIT = (PW+1)'(DEPTH);

  logic [PW-1:0]     aligned;
  logic [PW:0]       aligned_x;
  logic              fit_plain;
  logic              fit_burst;
  logic              room_merge;
  logic              same_burst;
  logic [PW-1:0]     cnt_inc;
  logic [PW-1:0]     free_inc;
  logic [DATA_W-1:0] hdr_plain;
  logic [DATA_W-1:0] hdr_burst;

  always_comb begin
    aligned    = free_q + {{(PW-1){1'b0}}, free_q[0]};
    aligned_x  = {1'b0, aligned};
    fit_plain  = (aligned_x + (PW+1)'(2)) <= LIMIT;
    fit_burst  = (aligned_x + (PW+1)'(3)) <= LIMIT;
    room_merge = free_q < PW'(DEPTH);
    same_burst = req_indexed && open_q && (req_offset == off_q);
    cnt_inc    = cnt_q + PW'(1);
    free_inc   = free_q + PW'(1);

    hdr_plain                   = '0;
    hdr_plain[DATA_W-1 -: 8]    = OP_PLAIN;
    hdr_plain[OFF_W +: 4]       = BE_ALL;
    hdr_plain[OFF_W-1:0]        = req_offset;
    hdr_burst                   = '0;
    hdr_burst[DATA_W-1 -: 8]    = OP_BURST;
    hdr_burst[OFF_W +: 4]       = BE_NONE;
    hdr_burst[OFF_W-1:0]        = req_offset;
  end

  always_comb begin
    act     = ACT_DROP;
    slot_n  = '0;
    free_d  = free_q;
    start_d = start_q;
    open_d  = open_q;
    off_d   = off_q;
    cnt_d   = cnt_q;
    for (int k = 0; k < int'(SLOTS); k++) begin
      slot_addr[k] = '0;
      slot_data[k] = '0;
    end

    if (same_burst) begin
      if (room_merge) begin
        act          = ACT_MERGE;
        slot_addr[0] = free_q[AW-1:0];
        slot_data[0] = req_value;
        slot_addr[1] = start_q;
        slot_data[1] = DATA_W'(cnt_inc);
        slot_n       = NW'(2);
        free_d       = free_inc;
        cnt_d        = cnt_inc;
        if (free_inc[0]) begin
          slot_addr[2] = free_inc[AW-1:0];
          slot_data[2] = '0;
          slot_n       = NW'(3);
        end
      end
    end else if (req_indexed) begin
      if (fit_burst) begin
        act          = ACT_OPEN;
        slot_addr[0] = aligned[AW-1:0];
        slot_data[0] = DATA_W'(1);
        slot_addr[1] = aligned[AW-1:0] + AW'(1);
        slot_data[1] = hdr_burst;
        slot_addr[2] = aligned[AW-1:0] + AW'(2);
        slot_data[2] = req_value;
        slot_addr[3] = aligned[AW-1:0] + AW'(3);
        slot_data[3] = '0;
        slot_n       = NW'(4);
        free_d       = aligned + PW'(3);
        start_d      = aligned[AW-1:0];
        open_d       = 1'b1;
        off_d        = req_offset;
        cnt_d        = PW'(1);
      end
    end else begin
      if (fit_plain) begin
        act          = ACT_PLAIN;
        slot_addr[0] = aligned[AW-1:0];
        slot_data[0] = req_value;
        slot_addr[1] = aligned[AW-1:0] + AW'(1);
        slot_data[1] = hdr_plain;
        slot_n       = NW'(2);
        free_d       = aligned + PW'(2);
        start_d      = aligned[AW-1:0];
        open_d       = 1'b0;
      end
    end
  end

endmodule

// File: rtl/regwr_state.sv
`timescale 1ns/1ps
// Bookkeeping registers: tail, instruction start, open-burst tracking, count
// and the sticky overflow flag.
module regwr_state
  import regwr_pack_pkg::*;
#(
  parameter int unsigned OFF_W = 20,
  parameter int unsigned AW    = 11,
  parameter int unsigned PW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             accept,
  input  act_e             act,
  input  logic [PW-1:0]    free_d,
  input  logic [AW-1:0]    start_d,
  input  logic             open_d,
  input  logic [OFF_W-1:0] off_d,
  input  logic [PW-1:0]    cnt_d,
  output logic [PW-1:0]    free_q,
  output logic [AW-1:0]    start_q,
  output logic             open_q,
  output logic [OFF_W-1:0] off_q,
  output logic [PW-1:0]    cnt_q,
  output logic             ovf_q
);

  logic             upd;
  logic             drop;
  logic             st_en;
  logic [PW-1:0]    free_n;
  logic [AW-1:0]    start_n;
  logic             open_n;
  logic [OFF_W-1:0] off_n;
  logic [PW-1:0]    cnt_n;
  logic             ovf_n;

  always_comb begin
    upd     = accept && (act != ACT_DROP);
    drop    = accept && (act == ACT_DROP);
    st_en   = clear || accept;
    free_n  = free_q;
    start_n = start_q;
    open_n  = open_q;
    off_n   = off_q;
    cnt_n   = cnt_q;
    ovf_n   = ovf_q;
    if (clear) begin
      free_n  = '0;
      start_n = '0;
      open_n  = 1'b0;
      off_n   = '0;
      cnt_n   = '0;
      ovf_n   = 1'b0;
    end else if (upd) begin
      free_n  = free_d;
      start_n = start_d;
      open_n  = open_d;
      off_n   = off_d;
      cnt_n   = cnt_d;
    end else if (drop) begin
      ovf_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q  <= '0;
      start_q <= '0;
      open_q  <= 1'b0;
      off_q   <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else if (st_en) begin
      free_q  <= free_n;
      start_q <= start_n;
      open_q  <= open_n;
      off_q   <= off_n;
      cnt_q   <= cnt_n;
      ovf_q   <= ovf_n;
    end
  end

endmodule

// File: rtl/regwr_emit.sv
`timescale 1ns/1ps
// Holds the planned dwords of one request and writes them out one per cycle.
module regwr_emit #(
  parameter int unsigned AW     = 11,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned NW     = $clog2(SLOTS + 1),
  parameter int unsigned IW     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [AW-1:0]     slot_addr_i [SLOTS],
  input  logic [DATA_W-1:0] slot_data_i [SLOTS],
  input  logic [NW-1:0]     slot_n_i,
  output logic              busy,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic [AW-1:0]     addr_v [SLOTS];
  logic [DATA_W-1:0] data_v [SLOTS];
  logic [NW-1:0]     rem_q;
  logic [NW-1:0]     rem_d;
  logic [IW-1:0]     idx_q;
  logic [IW-1:0]     idx_d;
  logic              step;
  logic              seq_en;

  for (genvar g = 0; g < int'(SLOTS); g++) begin : g_slot
    logic [AW-1:0]     a_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        d_q <= '0;
      end else if (load) begin
        a_q <= slot_addr_i[g];
        d_q <= slot_data_i[g];
      end
    end

    assign addr_v[g] = a_q;
    assign data_v[g] = d_q;
  end

  always_comb begin
    step   = (rem_q != '0);
    seq_en = clear || load || step;
    rem_d  = rem_q;
    idx_d  = idx_q;
    if (clear) begin
      rem_d = '0;
      idx_d = '0;
    end else if (load) begin
      rem_d = slot_n_i;
      idx_d = '0;
    end else if (step) begin
      rem_d = rem_q - NW'(1);
      idx_d = idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (seq_en) begin
      rem_q <= rem_d;
      idx_q <= idx_d;
    end
  end

  assign busy      = step;
  assign mem_we    = step;
  assign mem_addr  = addr_v[idx_q];
  assign mem_wdata = data_v[idx_q];

endmodule

// File: rtl/regwr_packer.sv
`timescale 1ns/1ps
module regwr_packer
  import regwr_pack_pkg::*;
#(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned OFF_W  = 20,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = $clog2(DEPTH),
  parameter int unsigned PW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_indexed,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_value,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [PW-1:0]     tail,
  output logic              overflow
);

  localparam int unsigned NW = $clog2(SLOTS + 1);

  act_e              act;
  logic [AW-1:0]     slot_addr [SLOTS];
  logic [DATA_W-1:0] slot_data [SLOTS];
  logic [NW-1:0]     slot_n;
  logic [PW-1:0]     free_d, free_q;
  logic [AW-1:0]     start_d, start_q;
  logic              open_d, open_q;
  logic [OFF_W-1:0]  off_d, off_q;
  logic [PW-1:0]     cnt_d, cnt_q;
  logic              ovf_q;
  logic              busy;
  logic              accept;
  logic              load;

  assign req_ready = !busy && !clear;
  assign accept    = req_valid && req_ready;
  assign load      = accept && (act != ACT_DROP);

  regwr_plan #(
    .DEPTH (DEPTH), .OFF_W (OFF_W), .DATA_W (DATA_W),
    .AW (AW), .PW (PW), .NW (NW)
  ) u_plan (
    .req_indexed (req_indexed),
    .req_offset  (req_offset),
    .req_value   (req_value),
    .free_q      (free_q),
    .start_q     (start_q),
    .open_q      (open_q),
    .off_q       (off_q),
    .cnt_q       (cnt_q),
    .act         (act),
    .slot_addr   (slot_addr),
    .slot_data   (slot_data),
    .slot_n      (slot_n),
    .free_d      (free_d),
    .start_d     (start_d),
    .open_d      (open_d),
    .off_d       (off_d),
    .cnt_d       (cnt_d)
  );

  regwr_state #(
    .OFF_W (OFF_W), .AW (AW), .PW (PW)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .accept  (accept),
    .act     (act),
    .free_d  (free_d),
    .start_d (start_d),
    .open_d  (open_d),
    .off_d   (off_d),
    .cnt_d   (cnt_d),
    .free_q  (free_q),
    .start_q (start_q),
    .open_q  (open_q),
    .off_q   (off_q),
    .cnt_q   (cnt_q),
    .ovf_q   (ovf_q)
  );

  regwr_emit #(
    .AW (AW), .DATA_W (DATA_W), .SLOTS (SLOTS), .NW (NW)
  ) u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .load        (load),
    .slot_addr_i (slot_addr),
    .slot_data_i (slot_data),
    .slot_n_i    (slot_n),
    .busy        (busy),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
  );

  assign tail     = free_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/regwr_packer_chk.sv
`timescale 1ns/1ps
module regwr_packer_chk #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned PW    = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_indexed,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [PW-1:0] tail,
  input logic          overflow
);

  AST_NO_ACCEPT_WHILE_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !req_ready); // R9

  AST_TAIL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    tail <= PW'(DEPTH)); // R7

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (tail == '0) && !overflow); // R8

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> !mem_we && (tail == $past(tail))); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(overflow) && !$past(clear)) |-> overflow); // R7

  AST_WRITE_WITHIN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, mem_addr} <= tail)); // R4

  AST_PLAIN_EVEN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready && !req_indexed) && (tail != $past(tail))) |-> !tail[0]); // R6

  AST_TAIL_ONLY_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(req_valid && req_ready) && !$past(clear)) |-> (tail == $past(tail))); // R9

endmodule

bind regwr_packer regwr_packer_chk #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clear       (clear),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_indexed (req_indexed),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .tail        (tail),
  .overflow    (overflow)
);

// File: tb/tb_regwr_packer.sv
`timescale 1ns/1ps
module tb_regwr_packer;

  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_indexed = 1'b0;
  logic [19:0] req_offset = '0;
  logic [31:0] req_value = '0;
  logic        mem_we;
  logic [10:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [11:0] tail;
  logic        overflow;

  always #2.5 clk = ~clk;

  regwr_packer dut (
    .clk (clk), .rst_n (rst_n), .clear (clear),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_indexed (req_indexed), .req_offset (req_offset), .req_value (req_value),
    .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .tail (tail), .overflow (overflow)
  );

  int checks = 0;
  int failures = 0;
  bit reported = 0;

  logic [31:0] dut_mem [DEPTH];
  logic [31:0] exp_mem [DEPTH];
  int wr_cnt = 0;

  int exp_free = 0, exp_start = 0, exp_cnt = 0;
  bit exp_open = 0, exp_ovf = 0;
  logic [19:0] exp_off = '0;

  always @(negedge clk) begin
    if (mem_we) begin
      dut_mem[mem_addr] = mem_wdata;
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  endtask

  initial begin
    #(5ns * 190000);
    chk(0, "R9", "watchdog expired", 0, 1);
    report();
  end

  // Reference model built from the requirements. kind: 0 drop, 1 plain, 2 open, 3 merge.
  task automatic model_req(input bit idx, input logic [19:0] off, input logic [31:0] val,
                           output int n, output int kind);
    int al;
    n = 0;
    kind = 0;
    al = exp_free + (exp_free % 2);
    if (idx && exp_open && off == exp_off) begin
      if (exp_free >= DEPTH) begin exp_ovf = 1; return; end
      exp_mem[exp_free] = val;
      exp_cnt++;
      exp_mem[exp_start] = exp_cnt;
      exp_free++;
      n = 2;
      kind = 3;
      if (exp_free % 2 == 1) begin exp_mem[exp_free] = 0; n = 3; end
    end else if (idx) begin
      if (al + 3 > DEPTH) begin exp_ovf = 1; return; end
      exp_mem[al]   = 1;
      exp_mem[al+1] = {8'h09, 4'h0, off};
      exp_mem[al+2] = val;
      exp_mem[al+3] = 0;
      exp_start = al; exp_free = al + 3; exp_open = 1; exp_off = off; exp_cnt = 1;
      n = 4;
      kind = 2;
    end else begin
      if (al + 2 > DEPTH) begin exp_ovf = 1; return; end
      exp_mem[al]   = val;
      exp_mem[al+1] = {8'h01, 4'hF, off};
      exp_start = al; exp_free = al + 2; exp_open = 0;
      n = 2;
      kind = 1;
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = -1;
    for (int i = 0; i < DEPTH; i++)
      if (bad < 0 && dut_mem[i] !== exp_mem[i]) bad = i;
    chk(bad < 0, req, "memory image", bad < 0 ? 0 : dut_mem[bad], bad < 0 ? 0 : exp_mem[bad]);
  endtask

  task automatic send(input bit idx, input logic [19:0] off, input logic [31:0] val);
    int n, kind, w0, lowc;
    string lbl;
    model_req(idx, off, val, n, kind);
    case (kind)
      1: lbl = "R1";
      2: lbl = "R2";
      3: lbl = "R3";
      default: lbl = "R7";
    endcase
    @(negedge clk);
    #1;
    w0 = wr_cnt;
    req_valid = 1'b1; req_indexed = idx; req_offset = off; req_value = val;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    lowc = 0;
    @(negedge clk);
    while (!req_ready) begin
      lowc++;
      @(negedge clk);
    end
    #1;
    chk(wr_cnt - w0 == n, "R9", "dwords written", wr_cnt - w0, n);
    chk(lowc == n, "R9", "ready-low cycles", lowc, n);
    chk(tail == 12'(exp_free), lbl, "tail", tail, exp_free);
    chk(overflow == exp_ovf, "R7", "overflow flag", overflow, exp_ovf);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(posedge clk);
    #1;
    clear = 1'b0;
    exp_free = 0; exp_start = 0; exp_open = 0; exp_ovf = 0; exp_cnt = 0;
    @(negedge clk);
    chk(tail == 0, "R8", "tail after clear", tail, 0);
    chk(!overflow, "R8", "overflow after clear", overflow, 0);
    chk(req_ready, "R8", "ready after clear", req_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      dut_mem[i] = 32'hDEAD_BEEF;
      exp_mem[i] = 32'hDEAD_BEEF;
    end
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(tail == 0, "R10", "tail at reset", tail, 0);
    chk(!overflow, "R10", "overflow at reset", overflow, 0);
    chk(req_ready, "R10", "ready at reset", req_ready, 1);
    chk(!mem_we, "R10", "write at reset", mem_we, 0);

    // Plain write at 0.
    send(0, 20'h00ABC, 32'h1111_0001);
    chk(dut_mem[1] == 32'h01F0_0ABC, "R1", "plain header", dut_mem[1], 32'h01F0_0ABC);
    // Burst opens at 2, padded at 5.
    send(1, 20'h00120, 32'h2222_0001);
    chk(dut_mem[3] == 32'h0900_0120, "R2", "burst header", dut_mem[3], 32'h0900_0120);
    chk(dut_mem[5] == 0, "R4", "pad after open", dut_mem[5], 0);
    // Two merges: tail 6 then 7 with a pad.
    send(1, 20'h00120, 32'h2222_0002);
    send(1, 20'h00120, 32'h2222_0003);
    chk(dut_mem[2] == 3, "R3", "burst count", dut_mem[2], 3);
    chk(dut_mem[7] == 0, "R4", "pad after merge", dut_mem[7], 0);
    // Different offset rounds 7 up to 8.
    send(1, 20'h00330, 32'h3333_0001);
    chk(tail == 11, "R6", "rounded burst tail", tail, 11);
    // Plain write between same-offset indexed writes closes the burst.
    send(0, 20'h00330, 32'h4444_0001);
    send(1, 20'h00330, 32'h4444_0002);
    chk(tail == 17, "R5", "reopened burst tail", tail, 17);
    cmp_mem("R5");

    // Clear closes the burst: same offset opens anew at 0.
    do_clear();
    send(1, 20'h00330, 32'h5555_0001);
    chk(tail == 3, "R8", "burst after clear", tail, 3);
    cmp_mem("R8");

    // Fill to 2042, open at 2042, merge to 2048, then a merge is dropped.
    do_clear();
    for (int i = 0; i < 1021; i++) send(0, 20'h00200, 32'(i));
    send(1, 20'h00300, 32'h6666_0001);
    send(1, 20'h00300, 32'h6666_0002);
    send(1, 20'h00300, 32'h6666_0003);
    send(1, 20'h00300, 32'h6666_0004);
    chk(tail == 2048, "R3", "full tail", tail, 2048);
    send(1, 20'h00300, 32'h6666_0005);
    chk(overflow, "R7", "merge drop flag", overflow, 1);
    cmp_mem("R7");

    // Fill to 2046: a new burst does not fit, a plain write does.
    do_clear();
    for (int i = 0; i < 1023; i++) send(0, 20'h00400, 32'(i + 7));
    send(1, 20'h00500, 32'h7777_0001);
    chk(tail == 2046, "R7", "tail after burst drop", tail, 2046);
    send(0, 20'h00500, 32'h7777_0002);
    send(0, 20'h00500, 32'h7777_0003);
    cmp_mem("R7");

    // Random mix with a fixed seed.
    do_clear();
    for (int i = 0; i < 400; i++) begin
      logic [19:0] offs [3];
      offs[0] = 20'h00100; offs[1] = 20'h00104; offs[2] = 20'hFFFFF;
      if ($urandom_range(0, 39) == 0) do_clear();
      send($urandom_range(0, 9) < 7, offs[$urandom_range(0, 2)], $urandom);
      if (i % 50 == 49) cmp_mem("R4");
    end
    cmp_mem("R3");

    report();
  end

endmodule